// File: doc/BRIEF.md
# Power-Mode-Aware Clock Controller

This block sits between the master-clock PLL of a low-power metering microcontroller and the logic that the PLL feeds. Each cycle of `clk` stands for one cycle of the master clock. The block decides from the power-mode inputs whether the PLL is powered, and it models PLL settling with a lock-delay counter loaded from `lock_cycles`. It produces a lock flag, a divided processor clock enable and a half-rate emulator clock enable. The analog PLL, the crystal oscillator and the real-time clock are outside the block.

Software controls the block through one control register at address 0x2200. The register holds a fast-mode request and a power-of-two divider code. In fast mode the master clock runs at 19.6608 MHz, which is 600 times the 32.768 kHz crystal. In slow mode it runs at 6.29 MHz. A request to change the fast/slow mode waits until the PLL reports lock, and the change itself restarts the lock delay. A new divider code takes effect only at the end of a divided period. Whenever the PLL wakes, it comes back in slow mode.

Top module: `clk_pwr_ctrl`

## Requirements
- R1: While reset is asserted, the following are all 0: `pll_on`, `pll_lock`, `pll_fast`, `mpu_ce`, `emu_ce` and the register contents (`rdata` reads 0 at the control address).
- R2: `pmode` codes are 00 active, 01 sleep, 10 LCD-only and 11 (treated as active). `pll_on` goes low one cycle after sleep is selected, or one cycle after LCD-only is selected with `lcd_boost` low. In every other case `pll_on` is high one cycle later.
- R3: `pll_lock` is low while the PLL is off. It rises `lock_cycles`+1 cycles after `pll_on` rises. It falls in the same cycle that `pll_fast` changes and rises again `lock_cycles`+1 cycles after that change.
- R4: While the PLL is off, `pll_fast` is 0, the stored fast request is cleared, and writes to the fast request bit are ignored. When `pll_on` rises, `pll_fast` is 0.
- R5: The control register sits at address 0x2200. Bit 4 is the fast request and bits [2:0] are the divider code. `rdata` shows these two fields combinationally when `addr` matches, and shows 0 for any other address. A write to any other address changes nothing.
- R6: A written divider code of 5, 6 or 7 is stored as 4 and reads back as 4.
- R7: While `pll_lock` is high, `mpu_ce` is a one-cycle pulse every 2^(code+2) cycles. While `pll_lock` is low, `mpu_ce` is never high.
- R8: A divider change takes effect only at a period boundary. The period in progress when the write lands finishes with the old ratio, and the following periods use the new ratio.
- R9: A fast-request change made while `pll_lock` is low leaves `pll_fast` unchanged until lock. `pll_fast` takes the requested value at the first clock edge at which `pll_lock` is high.
- R10: While `emu_en`, `pll_lock` and `pll_fast` are all high, `emu_ce` pulses on alternate cycles, starting in the second cycle. Otherwise `emu_ce` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (one reference cycle per edge) |
| rst_n | input | 1 | Asynchronous active-low reset |
| pmode | input | 2 | Power mode: 00 active, 01 sleep, 10 LCD-only, 11 active |
| lcd_boost | input | 1 | LCD boost enabled; keeps the PLL on in LCD-only mode |
| emu_en | input | 1 | Emulator attached; enables the emulator clock |
| lock_cycles | input | 16 | Settling delay of the modelled PLL, in cycles minus one |
| wr_en | input | 1 | Register write strobe |
| addr | input | 16 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data |
| pll_on | output | 1 | PLL powered |
| pll_fast | output | 1 | Applied PLL mode, 1 = fast |
| pll_lock | output | 1 | PLL output valid |
| mpu_ce | output | 1 | Divided processor clock enable |
| emu_ce | output | 1 | Half-rate emulator clock enable |

## Verification
The assertions take several things for granted about the block's inputs. `pmode`, `lcd_boost`, `emu_en` and the register inputs change only between rising edges. A write is a single-cycle strobe. `lock_cycles` is held constant while a settling interval is running. The stimulus meets all of this: it drives every input just after a falling edge, holds `lock_cycles` at 5 for the whole run, and issues each write as a one-cycle pulse. The divider scoreboard queues the pulse-to-pulse intervals it expects, including the one old-ratio period that straddles a divider write, and a monitor compares each measured interval against the head of the queue.

// File: rtl/clk_pwr_ctrl.sv
`timescale 1ns/1ps
module clk_pwr_ctrl #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int LCW      = 16,
  parameter int DIV_MAX  = 4,
  parameter int FAST_BIT = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h2200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        pmode,
  input  logic              lcd_boost,
  input  logic              emu_en,
  input  logic [LCW-1:0]    lock_cycles,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              pll_on,
  output logic              pll_fast,
  output logic              pll_lock,
  output logic              mpu_ce,
  output logic              emu_ce
);
  localparam int DCW = DIV_MAX + 2;
  localparam logic [2:0] DMAX = 3'(DIV_MAX);

  function automatic logic [DCW-1:0] top_of(input logic [2:0] d);
    top_of = '0;
    for (int i = 0; i < DCW; i++)
      if (i < int'(d) + 2) top_of[i] = 1'b1;
  endfunction

  logic           fast_req, etog;
  logic [2:0]     div_req, div_cur;
  logic [LCW-1:0] lcnt;
  logic [DCW-1:0] dcnt;
  logic           unused_wbits;

  wire need   = !(pmode == 2'b01 || (pmode == 2'b10 && !lcd_boost));
  wire hit    = (addr == CTRL_ADDR);
  wire wr     = wr_en && hit;
  wire [2:0] wdiv = (wdata[2:0] > DMAX) ? DMAX : wdata[2:0];
  wire [DCW-1:0] dlast = top_of(div_cur);
  wire emu_go = emu_en && pll_lock && pll_fast;

  assign unused_wbits = ^wdata;
  assign mpu_ce = pll_lock && (dcnt == dlast);
  assign emu_ce = emu_go && etog;

  always_comb begin
    rdata = '0;
    if (hit) begin
      rdata[FAST_BIT] = fast_req;
      rdata[2:0]      = div_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pll_on   <= 1'b0;
      pll_fast <= 1'b0;
      pll_lock <= 1'b0;
      fast_req <= 1'b0;
      lcnt     <= '0;
    end else if (!need) begin
      pll_on   <= 1'b0;
      pll_fast <= 1'b0;
      pll_lock <= 1'b0;
      fast_req <= 1'b0;
      lcnt     <= lock_cycles;
    end else begin
      pll_on <= 1'b1;
      if (wr) fast_req <= wdata[FAST_BIT];
      if (!pll_on) begin
        pll_lock <= 1'b0;
        lcnt     <= lock_cycles;
      end else if (pll_lock) begin
        if (pll_fast != fast_req) begin
          pll_fast <= fast_req;
          pll_lock <= 1'b0;
          lcnt     <= lock_cycles;
        end
      end else if (lcnt == '0) begin
        pll_lock <= 1'b1;
      end else begin
        lcnt <= lcnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_req <= '0;
      div_cur <= '0;
      dcnt    <= '0;
    end else begin
      if (wr) div_req <= wdiv;
      if (!pll_lock || dcnt == dlast) begin
        dcnt    <= '0;
        div_cur <= div_req;
      end else begin
        dcnt <= dcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) etog <= 1'b0;
    else        etog <= emu_go ? ~etog : 1'b0;
  end

  a_r2_sleep_off: assert property (@(posedge clk) disable iff (!rst_n)
    (pmode == 2'b01) |=> !pll_on);
  a_r3_lock_drop_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_on && pll_fast != $past(pll_fast)) |-> !pll_lock);
  a_r4_wake_slow: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_on) |-> !pll_fast);
  a_r6_div_bound: assert property (@(posedge clk) disable iff (!rst_n)
    div_req <= DMAX);
  a_r7_ce_locked: assert property (@(posedge clk) disable iff (!rst_n)
    mpu_ce |-> $past(pll_lock));
  a_r9_change_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_on && $past(pll_on) && pll_fast != $past(pll_fast)) |-> $past(pll_lock));
  a_r10_emu_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    emu_ce |=> !emu_ce);
endmodule

// File: tb/test_clk_pwr_ctrl.sv
`timescale 1ns/1ps
module test_clk_pwr_ctrl;
  localparam int N = 5;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] pmode = 2'b00;
  logic lcd_boost = 1'b0, emu_en = 1'b0, wr_en = 1'b0;
  logic [15:0] lock_cycles = 16'(N);
  logic [15:0] addr = 16'h2200;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic pll_on, pll_fast, pll_lock, mpu_ce, emu_ce;

  int total = 0, bad = 0, cyc = 0, last = 0, ce_unlocked = 0;
  bit have = 0;
  int q[$];

  clk_pwr_ctrl i_clk_pwr_ctrl (
    .clk(clk), .rst_n(rst_n), .pmode(pmode), .lcd_boost(lcd_boost),
    .emu_en(emu_en), .lock_cycles(lock_cycles), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pll_on(pll_on), .pll_fast(pll_fast),
    .pll_lock(pll_lock), .mpu_ce(mpu_ce), .emu_ce(emu_ce));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (mpu_ce && !pll_lock) ce_unlocked++;
      if (!pll_lock) have = 0;
      else if (mpu_ce) begin
        if (have && q.size() > 0) chk("R7/R8 ce interval", cyc - last, q.pop_front());
        have = 1;
        last = cyc;
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; addr = 16'h2200;
  endtask

  task automatic sched(input logic [7:0] d, input int oldp, input int newp);
    while (q.size() != 0) @(negedge clk);
    do @(negedge clk); while (!mpu_ce);
    #1;
    q.push_back(oldp); q.push_back(newp); q.push_back(newp);
    wr(16'h2200, d);
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic lock_count(input string req);
    int c = 0;
    while (!pll_lock) begin @(negedge clk); c++; end
    chk(req, c, N + 1);
  endtask

  initial begin
    int c, pulses, adj;
    logic prev;
    repeat (3) @(negedge clk);
    chk("R1 pll_on", pll_on, 0);  chk("R1 lock", pll_lock, 0);
    chk("R1 fast", pll_fast, 0);  chk("R1 rdata", rdata, 0);
    chk("R1 ce", mpu_ce | emu_ce, 0);
    rst_n = 1'b1;
    while (!pll_on) @(negedge clk);
    chk("R4 wake slow", pll_fast, 0);
    lock_count("R3 lock after power-up");

    sched(8'h00, 4, 4);
    sched(8'h03, 4, 32);
    chk("R5 readback div", rdata, 8'h03);
    sched(8'h01, 32, 8);
    sched(8'h07, 8, 64);
    chk("R6 clamp readback", rdata, 8'h04);
    sched(8'h00, 64, 4);

    wr(16'h2201, 8'h13);
    chk("R5 other addr ignored", rdata, 8'h00);
    addr = 16'h2201; #1;
    chk("R5 other addr reads 0", rdata, 0);
    addr = 16'h2200;

    wr(16'h2200, 8'h10);
    chk("R5 fast readback", rdata, 8'h10);
    while (!pll_fast) @(negedge clk);
    chk("R3 lock falls with change", pll_lock, 0);
    wr(16'h2200, 8'h00);
    c = 1;
    while (!pll_lock) begin
      chk("R9 held while unlocked", pll_fast, 1);
      @(negedge clk); c++;
    end
    chk("R3 lock after change", c, N + 1);
    chk("R9 still fast at lock", pll_fast, 1);
    @(negedge clk);
    chk("R9 applied after lock", pll_fast, 0);
    chk("R3 lock falls again", pll_lock, 0);
    lock_count("R3 relock slow");

    emu_en = 1'b1; pulses = 0;
    repeat (10) begin @(negedge clk); pulses += emu_ce; end
    chk("R10 no emu in slow", pulses, 0);
    emu_en = 1'b0;
    wr(16'h2200, 8'h10);
    while (!pll_fast) @(negedge clk);
    lock_count("R3 relock fast");
    emu_en = 1'b1; pulses = 0; adj = 0; prev = 1'b0;
    repeat (20) begin
      @(negedge clk);
      pulses += emu_ce;
      if (emu_ce && prev) adj++;
      prev = emu_ce;
    end
    chk("R10 emu pulses", pulses, 10);
    chk("R10 emu alternate", adj, 0);
    emu_en = 1'b0; pulses = 0;
    repeat (10) begin @(negedge clk); pulses += emu_ce; end
    chk("R10 emu disabled", pulses, 0);

    pmode = 2'b01;
    @(negedge clk);
    chk("R2 sleep off", pll_on, 0);
    chk("R3 lock low off", pll_lock, 0);
    chk("R4 fast cleared", pll_fast, 0);
    chk("R4 request cleared", rdata[4], 0);
    wr(16'h2200, 8'h12);
    chk("R4 fast write ignored", rdata, 8'h02);
    pmode = 2'b00;
    @(negedge clk);
    chk("R2 wake on", pll_on, 1);
    chk("R4 wake slow", pll_fast, 0);
    lock_count("R3 lock after wake");
    sched(8'h02, 16, 16);

    pmode = 2'b10; lcd_boost = 1'b0;
    @(negedge clk);
    chk("R2 lcd no boost off", pll_on, 0);
    lcd_boost = 1'b1;
    @(negedge clk);
    chk("R2 lcd boost on", pll_on, 1);
    pmode = 2'b11;
    repeat (3) @(negedge clk);
    chk("R2 code 11 on", pll_on, 1);
    chk("R7 no ce while unlocked", ce_unlocked, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(100000 * 5);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule